// File: doc/BRIEF.md
# Referenceless Frequency Acquisition Controller

This controller brings a clock-and-data-recovery loop onto the right frequency band without any reference clock. It sweeps the digital capacitor code of the oscillator one step at a time. After each step it watches a bit-error monitor that flags data transitions landing in the forbidden sampling zone. Time is divided into observation periods, each closed by a slow tick. A period counts as erroneous if at least one error event arrived during it. The controller compares the number of erroneous periods in a window against a threshold for the current stage.

Evaluation runs through escalating stages. A short, fast check rejects most wrong codes in a few periods, so the whole code range can be swept quickly. Codes that pass it face a medium check and then two long checks. While the sweep and the fast check run, the controller holds the integrating path of the loop filter at its centre. It releases that path once a code survives the fast check. A code that passes the first long check is recorded as the locked code and the loss-of-lock flag drops. The final long check then repeats for as long as the code keeps passing. A failure at any stage returns the controller to stepping.

States: `ACQ_STEP` (advance the code), `ACQ_FAST` (short check), `ACQ_MID` (medium check), `ACQ_LONG` (first long check), `ACQ_CONFIRM` (repeating long check while locked). Transitions: STEP→FAST always, after one cycle. FAST→MID, MID→LONG, LONG→CONFIRM and CONFIRM→CONFIRM happen on a passed window. Every stage goes to STEP on a failed window. A window passes when its erroneous-period count is strictly below that stage's threshold.

Top module: `cdr_freq_acq`

## Requirements
- R1: While reset is held, and in the first cycle after it, the state is STEP with `cap_code` = CAP_MAX, `loss_of_lock` = 1, `center_accum` = 1, `ber_reset` = 0 and `locked_code` = 0. The first code evaluated after reset is therefore 0.
- R2: STEP lasts exactly one cycle and adds one to `cap_code`. From CAP_MAX the code wraps to 0. In every other state `cap_code` holds its value.
- R3: On each entry into an evaluation state, including a repeated CONFIRM window, `ber_reset` is high for exactly one cycle. That cycle clears the period and error counts, and a tick arriving in that cycle is dropped.
- R4: An observation period is the run of cycles ending with a cycle in which `acq_tick` = 1. It adds at most one to the error count, and adds one only if `err_event` was 1 in at least one cycle of it (the tick cycle included).
- R5: A stage makes its decision only after exactly its window length of periods (FAST, MID, LONG, CONFIRM use WIN_FAST, WIN_MID, WIN_LONG, WIN_CONF). Fewer periods cause no transition and no `ber_reset` pulse.
- R6: FAST goes to MID if the count is below THR_FAST, otherwise to STEP.
- R7: MID goes to LONG if the count is below THR_MID, otherwise to STEP.
- R8: LONG goes to CONFIRM if the count is below THR_LONG. On that transition `locked_code` takes the current `cap_code` and `loss_of_lock` falls to 0. Otherwise LONG goes to STEP.
- R9: CONFIRM below THR_CONF starts a new CONFIRM window with `loss_of_lock` kept at 0. Otherwise it goes to STEP with `loss_of_lock` = 1 and `locked_code` unchanged.
- R10: `loss_of_lock` is 0 only in CONFIRM.
- R11: `center_accum` is 1 in STEP and FAST and 0 in MID, LONG and CONFIRM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_tick | input | 1 | One-cycle strobe closing each observation period |
| err_event | input | 1 | Forbidden-zone error event from the sampler |
| cap_code | output | CAP_W | Oscillator capacitor code being evaluated |
| locked_code | output | CAP_W | Code saved on reaching CONFIRM |
| center_accum | output | 1 | Holds the loop-filter integrator at its centre |
| ber_reset | output | 1 | One-cycle clear at the start of each window |
| loss_of_lock | output | 1 | High unless in CONFIRM |

## Verification
The bench builds the controller with CAP_W = 3 and CAP_MAX = 5, and with windows of 4, 6, 8 and 8 periods whose thresholds are 4, 5, 7 and 7. The short windows let a run reach every stage, and the tight thresholds put the pass/fail edge of each stage one erroneous period apart. A code limit below the full three-bit range selects the comparing wrap variant and brings the wrap from 5 to 0 within a few failed sweeps. Multiple error events inside single periods show that the count follows periods, not events.

// File: rtl/freq_acq_pkg.sv
`timescale 1ns/1ps
package freq_acq_pkg;

    typedef enum logic [2:0] {
        ACQ_STEP    = 3'd0,
        ACQ_FAST    = 3'd1,
        ACQ_MID     = 3'd2,
        ACQ_LONG    = 3'd3,
        ACQ_CONFIRM = 3'd4
    } acq_state_e;

    function automatic logic is_eval(input acq_state_e s);
        return (s != ACQ_STEP);
    endfunction

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/acq_period_counter.sv
`timescale 1ns/1ps
module acq_period_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic             err_event,
    input  logic [CNT_W-1:0] win_len,
    output logic [CNT_W-1:0] err_periods,
    output logic             win_done
);

    localparam logic [CNT_W-1:0] CNT_FULL = {CNT_W{1'b1}};

    logic             err_seen;
    logic [CNT_W-1:0] win_cnt;
    logic             period_hit;
    logic             last_period;

    assign period_hit  = err_seen | err_event;
    assign last_period = (win_cnt == (win_len - CNT_W'(1)));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_seen    <= 1'b0;
            win_cnt     <= '0;
            err_periods <= '0;
            win_done    <= 1'b0;
        end else if (clear) begin
            err_seen    <= 1'b0;
            win_cnt     <= '0;
            err_periods <= '0;
            win_done    <= 1'b0;
        end else begin
            win_done <= 1'b0;
            if (tick) begin
                err_seen <= 1'b0;
                if (period_hit && (err_periods != CNT_FULL)) begin
                    err_periods <= err_periods + CNT_W'(1);
                end
                if (last_period) begin
                    win_done <= 1'b1;
                    win_cnt  <= '0;
                end else begin
                    win_cnt <= win_cnt + CNT_W'(1);
                end
            end else if (err_event) begin
                err_seen <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/acq_cap_sweep.sv
`timescale 1ns/1ps
module acq_cap_sweep #(
    parameter int CAP_W   = 9,
    parameter int CAP_MAX = 335
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             save,
    output logic [CAP_W-1:0] cap_code,
    output logic [CAP_W-1:0] locked_code
);

    localparam logic [CAP_W-1:0] CAP_TOP = CAP_W'(CAP_MAX);
    localparam bit FULL_RANGE = (CAP_MAX == (2 ** CAP_W) - 1);

    logic [CAP_W-1:0] cap_next;

    generate
        if (FULL_RANGE) begin : g_natural_wrap
            assign cap_next = cap_code + CAP_W'(1);
        end else begin : g_compare_wrap
            assign cap_next = (cap_code >= CAP_TOP) ? '0 : (cap_code + CAP_W'(1));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_code    <= CAP_TOP;
            locked_code <= '0;
        end else begin
            if (step) begin
                cap_code <= cap_next;
            end
            if (save) begin
                locked_code <= cap_code;
            end
        end
    end

endmodule

// File: rtl/cdr_freq_acq.sv
`timescale 1ns/1ps
module cdr_freq_acq
    import freq_acq_pkg::*;
#(
    parameter int CAP_W     = 9,
    parameter int CAP_MAX   = 335,
    parameter int WIN_FAST  = 16,
    parameter int THR_FAST  = 16,
    parameter int WIN_MID   = 48,
    parameter int THR_MID   = 43,
    parameter int WIN_LONG  = 512,
    parameter int THR_LONG  = 501,
    parameter int WIN_CONF  = 512,
    parameter int THR_CONF  = 501
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acq_tick,
    input  logic             err_event,
    output logic [CAP_W-1:0] cap_code,
    output logic [CAP_W-1:0] locked_code,
    output logic             center_accum,
    output logic             ber_reset,
    output logic             loss_of_lock
);

    localparam int WIN_MAX = max_of4(WIN_FAST, WIN_MID, WIN_LONG, WIN_CONF);
    localparam int CNT_W   = $clog2(WIN_MAX + 1);

    acq_state_e       state_q;
    acq_state_e       state_n;
    logic [CNT_W-1:0] err_periods;
    logic             win_done;
    logic [CNT_W-1:0] cur_win;
    logic [CNT_W-1:0] cur_thr;
    logic             window_pass;
    logic             cap_step;
    logic             cap_save;

    // window length and threshold of the stage in progress
    always_comb begin
        unique case (state_q)
            ACQ_FAST: begin
                cur_win = CNT_W'(WIN_FAST);
                cur_thr = CNT_W'(THR_FAST);
            end
            ACQ_MID: begin
                cur_win = CNT_W'(WIN_MID);
                cur_thr = CNT_W'(THR_MID);
            end
            ACQ_LONG: begin
                cur_win = CNT_W'(WIN_LONG);
                cur_thr = CNT_W'(THR_LONG);
            end
            ACQ_CONFIRM: begin
                cur_win = CNT_W'(WIN_CONF);
                cur_thr = CNT_W'(THR_CONF);
            end
            default: begin
                cur_win = CNT_W'(WIN_FAST);
                cur_thr = CNT_W'(THR_FAST);
            end
        endcase
    end

    assign window_pass = (err_periods < cur_thr);

    acq_period_counter #(
        .CNT_W (CNT_W)
    ) period_cnt_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (ber_reset),
        .tick        (acq_tick),
        .err_event   (err_event),
        .win_len     (cur_win),
        .err_periods (err_periods),
        .win_done    (win_done)
    );

    // next-state decision
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ACQ_STEP:    state_n = ACQ_FAST;
            ACQ_FAST:    if (win_done) state_n = window_pass ? ACQ_MID     : ACQ_STEP;
            ACQ_MID:     if (win_done) state_n = window_pass ? ACQ_LONG    : ACQ_STEP;
            ACQ_LONG:    if (win_done) state_n = window_pass ? ACQ_CONFIRM : ACQ_STEP;
            ACQ_CONFIRM: if (win_done) state_n = window_pass ? ACQ_CONFIRM : ACQ_STEP;
            default:     state_n = ACQ_STEP;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACQ_STEP;
        end else begin
            state_q <= state_n;
        end
    end

    // registered outputs, aligned with the state they belong to
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ber_reset    <= 1'b0;
            loss_of_lock <= 1'b1;
            center_accum <= 1'b1;
        end else begin
            ber_reset    <= is_eval(state_n) && ((state_n != state_q) || win_done);
            loss_of_lock <= (state_n != ACQ_CONFIRM);
            center_accum <= (state_n == ACQ_STEP) || (state_n == ACQ_FAST);
        end
    end

    assign cap_step = (state_q == ACQ_STEP);
    assign cap_save = (state_q == ACQ_LONG) && (state_n == ACQ_CONFIRM);

    acq_cap_sweep #(
        .CAP_W   (CAP_W),
        .CAP_MAX (CAP_MAX)
    ) cap_sweep_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (cap_step),
        .save        (cap_save),
        .cap_code    (cap_code),
        .locked_code (locked_code)
    );

endmodule

// File: rtl/cdr_freq_acq_checker.sv
`timescale 1ns/1ps
module cdr_freq_acq_checker
    import freq_acq_pkg::*;
#(
    parameter int CAP_W   = 9,
    parameter int CAP_MAX = 335,
    parameter int CNT_W   = 10
) (
    input logic             clk,
    input logic             rst_n,
    input acq_state_e       state_q,
    input logic [CAP_W-1:0] cap_code,
    input logic [CAP_W-1:0] locked_code,
    input logic             center_accum,
    input logic             ber_reset,
    input logic             loss_of_lock,
    input logic [CNT_W-1:0] err_periods
);

    AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACQ_STEP) |=> (state_q == ACQ_FAST)); // R2
    AST_CAP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACQ_STEP && cap_code == CAP_W'(CAP_MAX)) |=> (cap_code == '0)); // R2
    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ACQ_STEP) |=> $stable(cap_code)); // R2
    AST_CLEAR_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACQ_STEP) |=> ber_reset); // R3
    AST_CLEAR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ber_reset |=> !ber_reset); // R3
    AST_ONE_PER_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (err_periods > $past(err_periods)) |-> (err_periods == $past(err_periods) + CNT_W'(1))); // R4
    AST_SAVE_ON_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(loss_of_lock) |-> (locked_code == cap_code)); // R8
    AST_LOCK_ONLY_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
        !loss_of_lock |-> (state_q == ACQ_CONFIRM)); // R10
    AST_CENTER_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACQ_FAST) |-> center_accum); // R11
    AST_CENTER_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACQ_MID || state_q == ACQ_LONG || state_q == ACQ_CONFIRM) |-> !center_accum); // R11

endmodule

bind cdr_freq_acq cdr_freq_acq_checker #(
    .CAP_W   (CAP_W),
    .CAP_MAX (CAP_MAX),
    .CNT_W   (CNT_W)
) checker_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_q      (state_q),
    .cap_code     (cap_code),
    .locked_code  (locked_code),
    .center_accum (center_accum),
    .ber_reset    (ber_reset),
    .loss_of_lock (loss_of_lock),
    .err_periods  (err_periods)
);

// File: tb/cdr_freq_acq_tb_top.sv
`timescale 1ns/1ps
module cdr_freq_acq_tb_top;

    localparam int CAP_W = 3;
    localparam int NROW  = 13;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acq_tick = 1'b0;
    logic             err_event = 1'b0;
    logic [CAP_W-1:0] cap_code;
    logic [CAP_W-1:0] locked_code;
    logic             center_accum;
    logic             ber_reset;
    logic             loss_of_lock;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    cdr_freq_acq #(
        .CAP_W(CAP_W), .CAP_MAX(5),
        .WIN_FAST(4), .THR_FAST(4),
        .WIN_MID(6),  .THR_MID(5),
        .WIN_LONG(8), .THR_LONG(7),
        .WIN_CONF(8), .THR_CONF(7)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .acq_tick(acq_tick), .err_event(err_event),
        .cap_code(cap_code), .locked_code(locked_code), .center_accum(center_accum),
        .ber_reset(ber_reset), .loss_of_lock(loss_of_lock)
    );

    // periods, erroneous periods, events per erroneous period,
    // expected cap, center, lock-loss, locked code after the window
    localparam int TBL [NROW][7] = '{
        '{4, 4, 1, 1, 1, 1, 0},
        '{4, 3, 2, 1, 0, 1, 0},
        '{6, 5, 1, 2, 1, 1, 0},
        '{4, 0, 1, 2, 0, 1, 0},
        '{6, 4, 1, 2, 0, 1, 0},
        '{8, 7, 1, 3, 1, 1, 0},
        '{4, 0, 1, 3, 0, 1, 0},
        '{6, 0, 1, 3, 0, 1, 0},
        '{8, 6, 1, 3, 0, 0, 3},
        '{8, 6, 1, 3, 0, 0, 3},
        '{8, 7, 1, 4, 1, 1, 3},
        '{4, 4, 1, 5, 1, 1, 3},
        '{4, 4, 1, 0, 1, 1, 3}
    };
    localparam string TAGS [NROW] = '{"R6", "R4", "R7", "R6", "R7", "R8", "R6",
                                      "R7", "R8", "R9", "R9", "R2", "R2"};

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic run_period(input bit with_err, input int events);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            err_event = with_err && (c < events) && (c < 3);
            acq_tick  = (c == 3);
        end
        @(negedge clk);
        err_event = 1'b0;
        acq_tick  = 1'b0;
    endtask

    // wait for the window-start clear pulse, then step past it
    task automatic sync_clear(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 40 && !seen; i++) begin
            @(negedge clk);
            if (ber_reset) seen = 1'b1;
        end
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        bit seen;
        int hits;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cap", int'(cap_code), 5);
        check("R1 lol", int'(loss_of_lock), 1);
        check("R1 center", int'(center_accum), 1);
        check("R1 ber_reset", int'(ber_reset), 0);
        check("R1 locked", int'(locked_code), 0);
        rst_n = 1'b1;
        sync_clear(seen);
        check("R3 first clear", int'(seen), 1);
        check("R1 first code", int'(cap_code), 0);

        for (int r = 0; r < NROW; r++) begin
            for (int p = 0; p < TBL[r][0]; p++) begin
                run_period(p < TBL[r][1], TBL[r][2]);
            end
            sync_clear(seen);
            check("R3 clear", int'(seen), 1);
            check(TAGS[r], int'(cap_code), TBL[r][3]);
            check("R11 center", int'(center_accum), TBL[r][4]);
            check("R10 lol", int'(loss_of_lock), TBL[r][5]);
            check("R8 locked", int'(locked_code), TBL[r][6]);
        end

        // R5: three erroneous periods in a four-period fast window decide nothing
        for (int p = 0; p < 3; p++) run_period(1'b1, 1);
        hits = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (ber_reset) hits++;
        end
        check("R5 no early clear", hits, 0);
        check("R5 cap held", int'(cap_code), 0);
        check("R5 center held", int'(center_accum), 1);
        run_period(1'b0, 1);
        sync_clear(seen);
        check("R5 decision", int'(seen), 1);
        check("R5 pass to mid", int'(center_accum), 0);

        // R1 reset in the middle of a run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 mid cap", int'(cap_code), 5);
        check("R1 mid lol", int'(loss_of_lock), 1);
        check("R1 mid center", int'(center_accum), 1);
        check("R1 mid locked", int'(locked_code), 0);
        rst_n = 1'b1;
        sync_clear(seen);
        check("R2 restart", int'(cap_code), 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule